// File: doc/BRIEF.md
# Bus Target Reselection Sequencer

This block is the target-side controller that reconnects a target to an initiator it left earlier on a parallel wired-OR bus. The target must already have won arbitration. Each bus line appears as a drive-enable output: a high level pulls the line true. Each line also has a sensed input, but only the sensed busy line is used here. A start strobe hands control to the block. From then on the block keeps busy and select asserted through the bus clear and settle interval. It then takes the target role by raising the direction line (I/O). It puts both device IDs on the data lines together with an odd parity bit.

Next the block performs a timed hand-off of busy ownership. It stops driving busy and lets the bus settle. It then watches for the initiator to raise busy within a bounded response window. When the initiator answers, the target drives busy again, waits two deskew intervals and frees select. It then pulses `done_o` and holds busy, I/O and the data byte until it is told to relinquish the bus. If no answer arrives, the block frees every line it drives, pulses `timeout_o` and returns to idle. All intervals are parameters counted in clock cycles.

Top module: `resel_target_seq`

## Requirements
- R1: While reset is high and after it is released with no start, every drive-enable output, `done_o` and `timeout_o` are 0.
- R2: A start accepted in idle drives busy and select from the next edge on, with I/O and data off, for exactly CLEAR_CYC+SETTLE_CYC cycles. I/O then rises while busy and select are still driven.
- R3: When I/O rises, the data lines carry a byte with bit number `own_id_i` set and bit number `init_id_i` set and every other bit clear. The parity line is 1 exactly when that byte has an even number of ones, so the nine lines together hold an odd count. Both IDs are captured at the accepted start, and later changes have no effect.
- R4: Busy stops being driven exactly 2*DESKEW_CYC cycles after I/O rises, while select, I/O and data stay driven.
- R5: For SETTLE_CYC cycles after busy is released, the sensed busy input is ignored.
- R6: Once the settle wait is over, a high sensed busy re-drives busy at the next edge. Select is then released exactly 2*DESKEW_CYC cycles later, and `done_o` is high for that single cycle.
- R7: From the rise of I/O until select is released, I/O, the data byte and parity do not change, unless the timeout releases them.
- R8: After select is released, busy, I/O, data and parity stay driven until `relinquish_i` is sampled high. The next edge then clears them all. A relinquish that arrives before select is released has no effect.
- R9: If sensed busy stays low for all TIMEOUT_CYC samples of the response window, the next edge clears select, I/O, data and parity (busy is already off) and pulses `timeout_o` for one cycle. The block is then idle.
- R10: A sensed busy on the final sample of the response window is treated as a response and not as a timeout.
- R11: A start strobe while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arbitration won; begin reselection |
| relinquish_i | input | 1 | Give up the bus after the hand-off |
| own_id_i | input | 3 | Target ID (bit number on the data bus) |
| init_id_i | input | 3 | Initiator ID (bit number on the data bus) |
| bsy_sense_i | input | 1 | Sensed state of the busy line |
| bsy_drv_o | output | 1 | Busy drive enable |
| sel_drv_o | output | 1 | Select drive enable |
| io_drv_o | output | 1 | I/O (direction) drive enable |
| db_drv_o | output | 8 | Data line drive enables |
| dbp_drv_o | output | 1 | Data parity drive enable |
| done_o | output | 1 | One-cycle pulse: hand-off complete |
| timeout_o | output | 1 | One-cycle pulse: no initiator response |

## Verification
Two events can fall in the same cycle: the initiator's response and the expiry of the response window. One scenario raises sensed busy exactly on the last sample of the window. The scoreboard then expects busy to be re-driven with no timeout pulse, followed by the normal select release and done pulse. Other scenarios cover three cases. A relinquish pulse arrives while busy is being re-driven but select is still held. A spurious busy arrives during the settle wait. A second start arrives mid-sequence. In each case the expected outputs stay those of the undisturbed timeline.

// File: rtl/resel_pkg.sv
package resel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_SETUP,
    ST_SETTLE,
    ST_RESP,
    ST_HOLD,
    ST_CONN
  } resel_state_t;

endpackage

// File: rtl/resel_counter.sv
module resel_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/resel_byte_gen.sv
module resel_byte_gen #(
  parameter int IDW = 3
) (
  input  logic [IDW-1:0]        own_id,
  input  logic [IDW-1:0]        peer_id,
  output logic [(1<<IDW)-1:0]   id_byte,
  output logic                  id_par
);

  localparam int DBW = 1 << IDW;

  for (genvar i = 0; i < DBW; i++) begin : g_bit
    assign id_byte[i] = (own_id == IDW'(i)) || (peer_id == IDW'(i));
  end

  // odd parity: the parity line makes the total count of ones odd
  assign id_par = ~(^id_byte);

endmodule

// File: rtl/resel_fsm.sv
module resel_fsm
  import resel_pkg::*;
#(
  parameter int DBW        = 8,
  parameter int CW         = 4,
  parameter int DESKEW_CYC = 2,
  parameter int SETTLE_CYC = 3,
  parameter int CLEAR_CYC  = 2,
  parameter int TIMEOUT_CYC = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           relinquish_i,
  input  logic           bsy_sense_i,
  input  logic           cnt_zero,
  input  logic [DBW-1:0] byte_in,
  input  logic           par_in,
  output logic           cnt_load,
  output logic [CW-1:0]  cnt_val,
  output logic           bsy_o,
  output logic           sel_o,
  output logic           io_o,
  output logic [DBW-1:0] db_o,
  output logic           dbp_o,
  output logic           done_o,
  output logic           timeout_o
);

  localparam logic [CW-1:0] ARB_LEN   = CW'(CLEAR_CYC + SETTLE_CYC - 1);
  localparam logic [CW-1:0] SKEW_LEN  = CW'(2 * DESKEW_CYC - 1);
  localparam logic [CW-1:0] SETL_LEN  = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RESP_LEN  = CW'(TIMEOUT_CYC - 1);

  resel_state_t  state_q;
  logic [DBW-1:0] byte_q;
  logic           par_q;

  // counter reload on every timed state entry
  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE:   if (start_i)     begin cnt_load = 1'b1; cnt_val = ARB_LEN;  end
      ST_ARB:    if (cnt_zero)    begin cnt_load = 1'b1; cnt_val = SKEW_LEN; end
      ST_SETUP:  if (cnt_zero)    begin cnt_load = 1'b1; cnt_val = SETL_LEN; end
      ST_SETTLE: if (cnt_zero)    begin cnt_load = 1'b1; cnt_val = RESP_LEN; end
      ST_RESP:   if (bsy_sense_i) begin cnt_load = 1'b1; cnt_val = SKEW_LEN; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      byte_q    <= '0;
      par_q     <= 1'b0;
      bsy_o     <= 1'b0;
      sel_o     <= 1'b0;
      io_o      <= 1'b0;
      db_o      <= '0;
      dbp_o     <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ARB;
            bsy_o   <= 1'b1;
            sel_o   <= 1'b1;
            byte_q  <= byte_in;
            par_q   <= par_in;
          end
        end
        ST_ARB: begin
          if (cnt_zero) begin
            state_q <= ST_SETUP;
            io_o    <= 1'b1;
            db_o    <= byte_q;
            dbp_o   <= par_q;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state_q <= ST_SETTLE;
            bsy_o   <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (cnt_zero) state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (bsy_sense_i) begin
            state_q <= ST_HOLD;
            bsy_o   <= 1'b1;
          end else if (cnt_zero) begin
            state_q   <= ST_IDLE;
            sel_o     <= 1'b0;
            io_o      <= 1'b0;
            db_o      <= '0;
            dbp_o     <= 1'b0;
            timeout_o <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            state_q <= ST_CONN;
            sel_o   <= 1'b0;
            done_o  <= 1'b1;
          end
        end
        ST_CONN: begin
          if (relinquish_i) begin
            state_q <= ST_IDLE;
            bsy_o   <= 1'b0;
            io_o    <= 1'b0;
            db_o    <= '0;
            dbp_o   <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/resel_target_seq.sv
module resel_target_seq #(
  parameter int IDW         = 3,
  parameter int DESKEW_CYC  = 2,
  parameter int SETTLE_CYC  = 3,
  parameter int CLEAR_CYC   = 2,
  parameter int TIMEOUT_CYC = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 relinquish_i,
  input  logic [IDW-1:0]       own_id_i,
  input  logic [IDW-1:0]       init_id_i,
  input  logic                 bsy_sense_i,
  output logic                 bsy_drv_o,
  output logic                 sel_drv_o,
  output logic                 io_drv_o,
  output logic [(1<<IDW)-1:0]  db_drv_o,
  output logic                 dbp_drv_o,
  output logic                 done_o,
  output logic                 timeout_o
);

  localparam int DBW   = 1 << IDW;
  localparam int L_ARB = CLEAR_CYC + SETTLE_CYC;
  localparam int L_SKW = 2 * DESKEW_CYC;
  localparam int M1    = (L_ARB > L_SKW) ? L_ARB : L_SKW;
  localparam int M2    = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int MAXV  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXV + 1);

  logic [DBW-1:0] id_byte;
  logic           id_par;
  logic           cnt_load;
  logic [CW-1:0]  cnt_val;
  logic           cnt_zero;

  resel_byte_gen #(.IDW(IDW)) u_byte (
    .own_id  (own_id_i),
    .peer_id (init_id_i),
    .id_byte (id_byte),
    .id_par  (id_par)
  );

  resel_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  resel_fsm #(
    .DBW         (DBW),
    .CW          (CW),
    .DESKEW_CYC  (DESKEW_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .CLEAR_CYC   (CLEAR_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .relinquish_i (relinquish_i),
    .bsy_sense_i  (bsy_sense_i),
    .cnt_zero     (cnt_zero),
    .byte_in      (id_byte),
    .par_in       (id_par),
    .cnt_load     (cnt_load),
    .cnt_val      (cnt_val),
    .bsy_o        (bsy_drv_o),
    .sel_o        (sel_drv_o),
    .io_o         (io_drv_o),
    .db_o         (db_drv_o),
    .dbp_o        (dbp_drv_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o)
  );

endmodule

// File: rtl/resel_checker.sv
module resel_checker #(
  parameter int DBW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           relinquish_i,
  input logic           bsy_drv_o,
  input logic           sel_drv_o,
  input logic           io_drv_o,
  input logic [DBW-1:0] db_drv_o,
  input logic           dbp_drv_o,
  input logic           done_o,
  input logic           timeout_o
);

  assert_io_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(io_drv_o) |-> (bsy_drv_o && sel_drv_o));

  assert_odd_parity_R3: assert property (@(posedge clk) disable iff (rst)
    io_drv_o |-> ((^{db_drv_o, dbp_drv_o}) == 1'b1));

  assert_done_shape_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (bsy_drv_o && !sel_drv_o && io_drv_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_sel_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_drv_o) |-> (done_o || timeout_o));

  assert_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_drv_o && io_drv_o) |=>
      ((io_drv_o && $stable(db_drv_o) && $stable(dbp_drv_o)) || timeout_o));

  assert_hold_bsy_R8: assert property (@(posedge clk) disable iff (rst)
    (!sel_drv_o && bsy_drv_o && !relinquish_i) |=> bsy_drv_o);

  assert_timeout_clear_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!bsy_drv_o && !sel_drv_o && !io_drv_o && db_drv_o == '0 && !dbp_drv_o));

  assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

endmodule

bind resel_target_seq resel_checker #(.DBW(1 << IDW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .relinquish_i (relinquish_i),
  .bsy_drv_o    (bsy_drv_o),
  .sel_drv_o    (sel_drv_o),
  .io_drv_o     (io_drv_o),
  .db_drv_o     (db_drv_o),
  .dbp_drv_o    (dbp_drv_o),
  .done_o       (done_o),
  .timeout_o    (timeout_o)
);

// File: tb/resel_target_seq_bench.sv
module resel_target_seq_bench;

  localparam int DSK = 2;
  localparam int STL = 3;
  localparam int CLR = 2;
  localparam int TO  = 6;

  typedef struct {
    logic       bsy, sel, io;
    logic [7:0] db;
    logic       p, done, to;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, relinquish_i = 1'b0, bsy_sense_i = 1'b0;
  logic [2:0] own_id_i = '0, init_id_i = '0;
  logic       bsy_drv_o, sel_drv_o, io_drv_o, dbp_drv_o, done_o, timeout_o;
  logic [7:0] db_drv_o;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  resel_target_seq #(
    .IDW(3), .DESKEW_CYC(DSK), .SETTLE_CYC(STL), .CLEAR_CYC(CLR), .TIMEOUT_CYC(TO)
  ) u_resel_target_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .relinquish_i(relinquish_i),
    .own_id_i(own_id_i), .init_id_i(init_id_i), .bsy_sense_i(bsy_sense_i),
    .bsy_drv_o(bsy_drv_o), .sel_drv_o(sel_drv_o), .io_drv_o(io_drv_o),
    .db_drv_o(db_drv_o), .dbp_drv_o(dbp_drv_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  function automatic exp_t idle_exp(input string tag);
    exp_t e;
    e.bsy = 0; e.sel = 0; e.io = 0; e.db = '0; e.p = 0; e.done = 0; e.to = 0;
    e.tag = tag;
    return e;
  endfunction

  // monitor: compare after each edge against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (bsy_drv_o !== e.bsy || sel_drv_o !== e.sel || io_drv_o !== e.io ||
            db_drv_o !== e.db || dbp_drv_o !== e.p || done_o !== e.done ||
            timeout_o !== e.to) begin
          errors++;
          $display("FAIL %s t=%0t actual bsy=%b sel=%b io=%b db=%h p=%b done=%b to=%b expected bsy=%b sel=%b io=%b db=%h p=%b done=%b to=%b",
                   e.tag, $time, bsy_drv_o, sel_drv_o, io_drv_o, db_drv_o, dbp_drv_o,
                   done_o, timeout_o, e.bsy, e.sel, e.io, e.db, e.p, e.done, e.to);
        end
      end
    end
  end

  // driver: one reselection attempt, expected outputs after each edge k
  task automatic scenario(input logic [2:0] own, input logic [2:0] init,
                          input int resp_j, input int rel_after,
                          input bit settle_noise, input bit restart_noise);
    int A, S, W, R, Q, T, last, ones;
    logic [7:0] eb;
    logic ep;
    A = CLR + STL;
    S = A + 2 * DSK;
    W = S + STL;
    T = W + 1 + TO;
    R = (resp_j > 0) ? (W + 1 + resp_j) : -1;
    Q = R + 2 * DSK + rel_after;
    last = (resp_j > 0) ? Q + 2 : T + 2;
    eb = '0;
    eb[own] = 1'b1;
    eb[init] = 1'b1;
    ones = 0;
    for (int b = 0; b < 8; b++) ones += int'(eb[b]);
    ep = ((ones % 2) == 0);
    for (int k = 1; k <= last; k++) begin
      exp_t e;
      @(negedge clk);
      start_i      = (k == 1) || (restart_noise && (k == 5 || k == A + 2));
      own_id_i     = (k == 1) ? own : ~own;
      init_id_i    = (k == 1) ? init : own ^ 3'd5;
      bsy_sense_i  = (settle_noise && k >= S + 2 && k <= W + 1) ||
                     (resp_j > 0 && k >= R && k <= R + 2 * DSK);
      relinquish_i = (resp_j > 0) && (k == Q || k == R + 1);
      e = idle_exp("R2");
      if (k <= A) begin
        e.bsy = 1; e.sel = 1; e.tag = "R2";
      end else if (k <= S) begin
        e.bsy = 1; e.sel = 1; e.io = 1; e.db = eb; e.p = ep;
        e.tag = (k == A + 1) ? "R3" : "R4";
      end else if (k <= W) begin
        e.sel = 1; e.io = 1; e.db = eb; e.p = ep; e.tag = "R5";
      end else if (resp_j > 0) begin
        if (k < R) begin
          e.sel = 1; e.io = 1; e.db = eb; e.p = ep; e.tag = "R7";
        end else if (k < R + 2 * DSK) begin
          e.bsy = 1; e.sel = 1; e.io = 1; e.db = eb; e.p = ep;
          e.tag = (k == R && resp_j == TO) ? "R10" : "R6";
        end else if (k == R + 2 * DSK) begin
          e.bsy = 1; e.io = 1; e.db = eb; e.p = ep; e.done = 1; e.tag = "R6";
        end else if (k <= Q) begin
          e.bsy = 1; e.io = 1; e.db = eb; e.p = ep; e.tag = "R8";
          if (k == Q) begin
            e.bsy = 0; e.io = 0; e.db = '0; e.p = 0;
          end
        end else begin
          e.tag = "R8";
        end
      end else begin
        if (k < T) begin
          e.sel = 1; e.io = 1; e.db = eb; e.p = ep;
          e.tag = settle_noise ? "R5" : "R9";
        end else if (k == T) begin
          e.to = 1; e.tag = "R9";
        end else begin
          e.tag = "R9";
        end
      end
      if (restart_noise && (k == 6 || k == A + 3)) e.tag = "R11";
      q.push_back(e);
    end
    @(negedge clk);
    start_i = 0; relinquish_i = 0; bsy_sense_i = 0;
    q.push_back(idle_exp("R1"));
  endtask

  initial begin
    // R1: outputs idle during and after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      q.push_back(idle_exp("R1"));
    end
    @(negedge clk);
    rst = 1'b0;
    q.push_back(idle_exp("R1"));
    @(negedge clk);
    q.push_back(idle_exp("R1"));

    scenario(3'd7, 3'd0, 1, 3, 1'b0, 1'b0);   // early response
    scenario(3'd3, 3'd5, TO, 1, 1'b0, 1'b0);  // R10 response on final sample
    scenario(3'd2, 3'd6, 0, 0, 1'b1, 1'b0);   // R5 noise in settle, then R9 timeout
    scenario(3'd1, 3'd4, 3, 2, 1'b0, 1'b1);   // R11 restart strobes ignored
    scenario(3'd0, 3'd0, 0, 0, 1'b0, 1'b0);   // R3 equal IDs: single bit, parity 0

    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule